// File: doc/BRIEF.md
# Register-Driven Serial Configuration Loader

This block lets a host load a programmable fabric's configuration through two registers in a bus configuration space. A 16-bit control/status register at dword address 0x10 (byte address 0x40) holds the session-start bit, an active-low program bit and a sticky overrun flag. It also reports shifter-empty, fabric-done and bus-ownership status. A 32-bit data register at dword address 0x11 (byte address 0x44) takes one configuration word per write.

Each accepted word goes into a shift register. The word is then sent one bit per clock on `ser_data`, most significant bit first. `ser_clk_en` qualifies each bit. Together the two outputs form a stream like the one an external serial memory would feed the fabric's configuration port. `prog_n` drives the fabric's program/reset line directly from the program bit. The host polls shifter-empty before it writes each word.

The register port has no read strobe: `reg_rdata` shows the register selected by `reg_addr` in the same cycle. Writes take effect at the clock edge that samples `reg_we`.

Top module: `fabric_cfg_loader`

## Requirements
- R1: After reset the CSR reads 0x1011 when `fab_done`=0 and `scan_busy`=0. Start (bit 14) and overrun (bit 5) are 0, program (bit 12) and shifter-empty (bit 4) are 1, `prog_n`=1 and `ser_clk_en`=0.
- R2: CSR bit 0 reads as the inverse of `scan_busy` and CSR bit 1 reads as `fab_done`, with no delay.
- R3: A CSR write with `reg_be[1]`=1 stores `reg_wdata[12]` into the program bit, and `prog_n` equals that bit from the next cycle on.
- R4: A data register write is ignored when start is 0 or `scan_busy` is 1. No stream is produced, shifter-empty stays 1 and overrun stays 0.
- R5: An accepted data word produces exactly 32 consecutive `ser_clk_en` cycles. These start in the cycle after the write, and `ser_data` carries bits 31 down to 0 in that order.
- R6: Shifter-empty reads 0 from the cycle after an accepted write. It reads 1 again in the first cycle that `ser_clk_en` is low after the 32nd bit.
- R7: A data write made while start=1, `scan_busy`=0 and shifter-empty=0 is dropped and sets the overrun bit (bit 5). Writing 1 to bit 5 with `reg_be[0]`=1 clears it.
- R8: CSR bits 2, 3, 6-11, 13, 15 and `reg_rdata[31:16]` read as zero. The data register reads as zero.
- R9: A CSR write that clears start stops any word in progress. From the next cycle `ser_clk_en` is 0 and shifter-empty is 1.
- R10: CSR byte lane 1 (`reg_be[1]`) controls bits 12 and 14, and byte lane 0 (`reg_be[0]`) controls the overrun clear. A lane that is not enabled leaves its bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Dword address (0x10 CSR, 0x11 data) |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| fab_done | input | 1 | Fabric reports configuration finished |
| scan_busy | input | 1 | Boundary-scan controller owns configuration |
| ser_data | output | 1 | Serial configuration data, MSB first |
| ser_clk_en | output | 1 | Qualifies one serial bit per cycle |
| prog_n | output | 1 | Active-low program/reset to the fabric |

## Verification
The hardest case to reach is a register write landing while a word is partway out of the shifter. This includes a second data write that must raise overrun without disturbing the stream, and a start-clear that must cut the stream mid-word. The scoreboard queues the expected bits when a word is issued and pops one bit per `ser_clk_en` cycle. The driver issues the overrun write and the abort write a known number of cycles into a word, then flushes the queue. Any stray bit after the cut therefore shows up as an unexpected pulse.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
    localparam int WORD_W       = 32;
    localparam int ADDR_W       = 6;
    localparam int CSR_W        = 16;
    localparam logic [ADDR_W-1:0] CSR_DWADDR  = 6'h10;
    localparam logic [ADDR_W-1:0] DATA_DWADDR = 6'h11;

    localparam int B_FREE    = 0;
    localparam int B_DONE    = 1;
    localparam int B_EMPTY   = 4;
    localparam int B_OVR     = 5;
    localparam int B_PROG    = 12;
    localparam int B_START   = 14;

    typedef struct packed {
        logic prog_n;
        logic start;
        logic overrun;
    } ctl_t;
endpackage

// File: rtl/cfg_ldr_ctl.sv
module cfg_ldr_ctl
    import cfg_ldr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [1:0]       csr_be,
    input  logic [CSR_W-1:0] csr_wdata,
    input  logic             set_ovr,
    output logic             abort,
    output ctl_t             ctl
);
    ctl_t ctl_d, ctl_q;

    assign abort = csr_wr && csr_be[1] && !csr_wdata[B_START];

    always_comb begin
        ctl_d = ctl_q;
        if (csr_wr && csr_be[1]) begin
            ctl_d.prog_n = csr_wdata[B_PROG];
            ctl_d.start  = csr_wdata[B_START];
        end
        if (csr_wr && csr_be[0] && csr_wdata[B_OVR]) begin
            ctl_d.overrun = 1'b0;
        end
        if (set_ovr) begin
            ctl_d.overrun = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{prog_n: 1'b1, start: 1'b0, overrun: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/cfg_ldr_shifter.sv
module cfg_ldr_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         abort,
    output logic         ser_data,
    output logic         ser_clk_en,
    output logic         empty
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

    typedef struct packed {
        logic [W-1:0]     shreg;
        logic [CNT_W-1:0] left;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (abort) begin
            sh_d.shreg = '0;
            sh_d.left  = '0;
        end else if (load) begin
            sh_d.shreg = word;
            sh_d.left  = FULL;
        end else if (sh_q.left != '0) begin
            sh_d.shreg = {sh_q.shreg[W-2:0], 1'b0};
            sh_d.left  = sh_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign ser_data   = sh_q.shreg[W-1];
    assign ser_clk_en = (sh_q.left != '0);
    assign empty      = (sh_q.left == '0);
endmodule

// File: rtl/cfg_ldr_rdmux.sv
module cfg_ldr_rdmux
    import cfg_ldr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  ctl_t              ctl,
    input  logic              empty,
    input  logic              fab_done,
    input  logic              scan_busy,
    output logic [WORD_W-1:0] rdata
);
    logic [CSR_W-1:0] csr_view;

    always_comb begin
        csr_view          = '0;
        csr_view[B_FREE]  = !scan_busy;
        csr_view[B_DONE]  = fab_done;
        csr_view[B_EMPTY] = empty;
        csr_view[B_OVR]   = ctl.overrun;
        csr_view[B_PROG]  = ctl.prog_n;
        csr_view[B_START] = ctl.start;
        rdata = '0;
        if (addr == CSR_DWADDR) begin
            rdata = {{(WORD_W-CSR_W){1'b0}}, csr_view};
        end
    end
endmodule

// File: rtl/fabric_cfg_loader.sv
module fabric_cfg_loader
    import cfg_ldr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [3:0]        reg_be,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              fab_done,
    input  logic              scan_busy,
    output logic              ser_data,
    output logic              ser_clk_en,
    output logic              prog_n
);
    ctl_t ctl;
    logic abort;
    logic csr_wr;
    logic data_wr;
    logic data_ok;
    logic sh_empty;
    logic start_q;
    logic ovr_q;

    assign csr_wr  = reg_we && (reg_addr == CSR_DWADDR);
    assign data_wr = reg_we && (reg_addr == DATA_DWADDR);
    assign data_ok = data_wr && ctl.start && !scan_busy;

    cfg_ldr_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (csr_wr),
        .csr_be    (reg_be[1:0]),
        .csr_wdata (reg_wdata[CSR_W-1:0]),
        .set_ovr   (data_ok && !sh_empty),
        .abort     (abort),
        .ctl       (ctl)
    );

    cfg_ldr_shifter #(.W(WORD_W)) u_sh (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (data_ok && sh_empty),
        .word       (reg_wdata),
        .abort      (abort),
        .ser_data   (ser_data),
        .ser_clk_en (ser_clk_en),
        .empty      (sh_empty)
    );

    cfg_ldr_rdmux u_rd (
        .addr      (reg_addr),
        .ctl       (ctl),
        .empty     (sh_empty),
        .fab_done  (fab_done),
        .scan_busy (scan_busy),
        .rdata     (reg_rdata)
    );

    assign start_q = ctl.start;
    assign ovr_q   = ctl.overrun;
    assign prog_n  = ctl.prog_n;
endmodule

// File: rtl/cfg_ldr_chk.sv
module cfg_ldr_chk
    import cfg_ldr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [3:0]        reg_be,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              fab_done,
    input logic              scan_busy,
    input logic              ser_clk_en,
    input logic              prog_n,
    input logic              start_q,
    input logic              empty,
    input logic              ovr_q
);
    logic csr_w, data_w;
    assign csr_w  = reg_we && reg_addr == CSR_DWADDR;
    assign data_w = reg_we && reg_addr == DATA_DWADDR;

    p_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == CSR_DWADDR) |-> (reg_rdata[0] == !scan_busy && reg_rdata[1] == fab_done));

    p_prog_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_w && reg_be[1]) |=> (prog_n == $past(reg_wdata[B_PROG])));

    p_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_w && scan_busy && empty) |=> (empty && !ser_clk_en));

    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_w && start_q && !scan_busy && empty) |=> (!empty && ser_clk_en));

    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_w && start_q && !scan_busy && !empty) |=> ovr_q);

    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == CSR_DWADDR) |-> ((reg_rdata & 32'hFFFF_AFCC) == 32'h0));

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_w && reg_be[1] && !reg_wdata[B_START]) |=> (!ser_clk_en && empty));

    p_idle_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q |-> !ser_clk_en);
endmodule

bind fabric_cfg_loader cfg_ldr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_be     (reg_be),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .fab_done   (fab_done),
    .scan_busy  (scan_busy),
    .ser_clk_en (ser_clk_en),
    .prog_n     (prog_n),
    .start_q    (start_q),
    .empty      (sh_empty),
    .ovr_q      (ovr_q)
);

// File: tb/fabric_cfg_loader_test.sv
`timescale 1ns/1ps
module fabric_cfg_loader_test;
    localparam logic [5:0] A_CSR  = 6'h10;
    localparam logic [5:0] A_DATA = 6'h11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = A_CSR;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fab_done = 1'b0;
    logic        scan_busy = 1'b0;
    logic        ser_data, ser_clk_en, prog_n;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int pushed = 0;
    bit exp_q[$];
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    fabric_cfg_loader uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fab_done(fab_done), .scan_busy(scan_busy), .ser_data(ser_data),
        .ser_clk_en(ser_clk_en), .prog_n(prog_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop one expected bit per qualified serial cycle (R5)
    always @(negedge clk) begin
        if (rst_n && ser_clk_en) begin
            pulses++;
            if (exp_q.size() == 0) begin
                check("R5 unexpected serial pulse", 32'd1, 32'd0);
            end else begin
                check("R5 serial bit", {31'd0, ser_data}, {31'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_be = 4'h0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    // Driver: push the expected stream, then issue the data write
    task automatic send_word(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) begin
            exp_q.push_back(w[i]);
        end
        pushed += 32;
        wr(A_DATA, 4'hF, w);
    endtask

    task automatic idle_cycles(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, {31'd0, ser_clk_en}, 32'd0);
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        rd(A_CSR, r);
        check("R1 csr reset", r, 32'h0000_1011);
        check("R1 prog_n reset", {31'd0, prog_n}, 32'd1);
        check("R1 clk_en reset", {31'd0, ser_clk_en}, 32'd0);

        // R2 status inputs
        fab_done = 1'b1; scan_busy = 1'b1;
        rd(A_CSR, r);
        check("R2 done/free", {30'd0, r[1:0]}, 32'd2);
        fab_done = 1'b0; scan_busy = 1'b0;
        rd(A_CSR, r);
        check("R2 done/free idle", {30'd0, r[1:0]}, 32'd1);

        // R3 program toggle high, low, high
        wr(A_CSR, 4'h3, 32'h0000_1000);
        check("R3 prog high", {31'd0, prog_n}, 32'd1);
        wr(A_CSR, 4'h3, 32'h0000_0000);
        check("R3 prog low", {31'd0, prog_n}, 32'd0);
        wr(A_CSR, 4'h3, 32'h0000_1000);
        check("R3 prog high again", {31'd0, prog_n}, 32'd1);

        // R4 data write before start is ignored
        wr(A_DATA, 4'hF, 32'hFFFF_FFFF);
        idle_cycles(4, "R4 no stream without start");
        rd(A_CSR, r);
        check("R4 empty/overrun untouched", {30'd0, r[5:4]}, 32'd1);

        // start session
        wr(A_CSR, 4'h3, 32'h0000_5000);
        rd(A_CSR, r);
        check("R1 start set", {31'd0, r[14]}, 32'd1);

        // R4 data write while scan owns configuration is ignored
        scan_busy = 1'b1;
        wr(A_DATA, 4'hF, 32'hFFFF_FFFF);
        idle_cycles(4, "R4 no stream while scan busy");
        scan_busy = 1'b0;
        rd(A_CSR, r);
        check("R4 overrun stays clear", {31'd0, r[5]}, 32'd0);

        // R5/R6 first word and empty timing
        send_word(32'hA5C3_0F96);
        rd(A_CSR, r);
        check("R6 empty cleared after write", {31'd0, r[4]}, 32'd0);
        repeat (31) @(posedge clk);
        #1 rd(A_CSR, r);
        check("R6 empty low during last bit", {31'd0, r[4]}, 32'd0);
        @(posedge clk); #1;
        rd(A_CSR, r);
        check("R6 empty set after 32nd bit", {31'd0, r[4]}, 32'd1);
        check("R5 clk_en idle after word", {31'd0, ser_clk_en}, 32'd0);
        check("R5 pulse count", pulses, 32);

        // R5 back-to-back words, other patterns
        send_word(32'h8000_0001);
        repeat (32) @(posedge clk);
        send_word(32'h1234_5678);
        repeat (32) @(posedge clk);
        #1 check("R5 pulse count 3 words", pulses, 96);

        // R7 overrun: second write while busy is dropped
        send_word(32'h0F0F_F0F0);
        repeat (3) @(posedge clk);
        wr(A_DATA, 4'hF, 32'hDEAD_BEEF);
        rd(A_CSR, r);
        check("R7 overrun set", {31'd0, r[5]}, 32'd1);
        repeat (30) @(posedge clk);
        #1 check("R7 dropped word not streamed", pulses, 128);
        // R10 lane 0 disabled: overrun not cleared
        wr(A_CSR, 4'h2, 32'h0000_5020);
        rd(A_CSR, r);
        check("R10 overrun kept without lane0", {31'd0, r[5]}, 32'd1);
        wr(A_CSR, 4'h1, 32'h0000_0020);
        rd(A_CSR, r);
        check("R7 overrun W1C", {31'd0, r[5]}, 32'd0);
        check("R10 start kept without lane1", {31'd0, r[14]}, 32'd1);

        // R8 reserved bits and data read
        wr(A_CSR, 4'hF, 32'hFFFF_FFFF);
        rd(A_CSR, r);
        check("R8 reserved zero", r, 32'h0000_5011);
        rd(A_DATA, r);
        check("R8 data reads zero", r, 32'h0);

        // R9 abort mid-word
        send_word(32'hFFFF_0000);
        repeat (5) @(posedge clk);
        wr(A_CSR, 4'h3, 32'h0000_1000);
        exp_q.delete();
        rd(A_CSR, r);
        check("R9 empty after abort", {31'd0, r[4]}, 32'd1);
        idle_cycles(5, "R9 stream stopped");
        check("R9 pulses cut short", (pulses > 128 && pulses < 160) ? 32'd1 : 32'd0, 32'd1);

        check("R5 scoreboard drained", exp_q.size(), 0);
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule